// File: doc/BRIEF.md
# I2C Register Target with SCL-Low Watchdog

This block is an I2C target that exposes a 256-byte address space to a bus master. Locations 00h to 13h are timekeeping and control registers, and locations 14h to FFh are general-purpose RAM. The register storage sits outside the block. The block reaches it through a one-cycle write strobe and a combinational read port. A master sets an internal byte pointer with the first data byte of a write transfer. It can then stream more bytes into consecutive locations, or read consecutive locations back. The pointer advances automatically in both cases.

SCL and SDA arrive as raw levels and are oversampled by the system clock. The block drives SDA only through an open-drain pull-down enable. A watchdog counts system-clock cycles while SCL stays low during a transfer. When the count reaches a parameter value, the protocol engine drops back to idle, and any byte that was not fully received is discarded. This timeout sets the slowest bus clock the block can work with.

Top module: `i2c_regfile_target`

## Requirements
- R1: After START, the block compares the first 7 received bits (MSB first) with `DEV_ADDR`. The 8th bit selects the direction: 0 means write, 1 means read. On a match the block acknowledges by pulling SDA low for the 9th clock. On a mismatch it gives no acknowledge and ignores all bus activity until the next START.
- R2: In a write transfer, the first data byte loads the pointer and causes no write. Each later byte causes exactly one single-cycle `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer then increments.
- R3: The pointer wraps from FFh to 00h.
- R4: In a read transfer, each byte is sent MSB first. Its value is taken from `rd_data` while `rd_addr` shows the current pointer, so reading starts at the pointer. The pointer increments after each byte is fetched.
- R5: `wr_is_ram` is 1 during a write to 14h–FFh and 0 during a write to 00h–13h.
- R6: When the master answers a read byte with NACK (SDA high on the 9th clock), the block stops driving SDA and goes idle.
- R7: A STOP (SDA rising while SCL is high) returns the block to idle and leaves the pointer unchanged.
- R8: If SCL stays low for `TIMEOUT_CYC` system clocks during a transfer, the block goes idle. A partly received byte is not written, and the block does not acknowledge anything until the next START.
- R9: A START (SDA falling while SCL is high) restarts the address phase from any state, including in the middle of a byte.
- R10: After reset, SDA is released, `wr_en` is low and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_en | output | 1 | One-cycle write strobe to register storage |
| wr_addr | output | 8 | Write location |
| wr_data | output | 8 | Write byte |
| wr_is_ram | output | 1 | Write targets the RAM region |
| rd_addr | output | 8 | Current pointer, used as the read location |
| rd_data | input | 8 | Byte stored at `rd_addr` |

## Verification
The bench runs writes that cross the boundary between the register region and the RAM region, and writes and reads that wrap across FFh. Together these separate pointer increment, wrap and address decoding. A pointer-only write followed by reads shows that the first data byte only loads the pointer. A read issued straight after reset shows the reset pointer value. A transfer to a foreign address, a transfer frozen with SCL held low in the middle of a byte, and a transfer broken by a repeated START each show a different path back to the address phase. The first two must leave storage untouched. The third must still complete the transfer that follows it.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         TIMEOUT_CYC = 200,
  parameter logic [7:0] RAM_BASE    = 8'h14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wr_is_ram,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {IDLE, RX, ACK, TX, MACK} st_t;
  st_t st;

  logic [2:0] scl_q, sda_q;
  logic [7:0] sh, ptr;
  logic [2:0] bcnt;
  logic       got8, is_addr, rw, first, mnak;
  logic [TW-1:0] to_cnt;

  wire scl_s = scl_q[1], scl_p = scl_q[2];
  wire sda_s = sda_q[1], sda_p = sda_q[2];
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise = scl_s & ~scl_p;
  wire fall = ~scl_s & scl_p;
  wire to_hit = (to_cnt == TW'(TIMEOUT_CYC));
  wire idle = (st == IDLE);

  assign sda_pull  = (st == ACK) | ((st == TX) & ~sh[7]);
  assign wr_is_ram = (wr_addr >= RAM_BASE);
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      sh      <= '0;
      ptr     <= '0;
      bcnt    <= '0;
      got8    <= 1'b0;
      is_addr <= 1'b0;
      rw      <= 1'b0;
      first   <= 1'b0;
      mnak    <= 1'b0;
      to_cnt  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (idle || scl_s) to_cnt <= '0;
      else if (!to_hit)  to_cnt <= to_cnt + TW'(1);

      if (start_det) begin
        st      <= RX;
        is_addr <= 1'b1;
        bcnt    <= '0;
        got8    <= 1'b0;
      end else if (stop_det) begin
        st <= IDLE;
      end else if (to_hit) begin
        st     <= IDLE;
        to_cnt <= '0;
      end else begin
        case (st)
          RX: begin
            if (rise && !got8) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 3'd1;
              got8 <= (bcnt == 3'd7);
            end else if (fall && got8) begin
              got8 <= 1'b0;
              if (is_addr) begin
                is_addr <= 1'b0;
                if (sh[7:1] == DEV_ADDR) begin
                  rw    <= sh[0];
                  first <= ~sh[0];
                  st    <= ACK;
                end else begin
                  st <= IDLE;
                end
              end else begin
                st <= ACK;
                if (first) begin
                  ptr   <= sh;
                  first <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 8'd1;
                end
              end
            end
          end
          ACK: if (fall) begin
            bcnt <= '0;
            if (rw) begin
              sh  <= rd_data;
              ptr <= ptr + 8'd1;
              st  <= TX;
            end else begin
              st <= RX;
            end
          end
          TX: if (fall) begin
            if (bcnt == 3'd7) st <= MACK;
            sh   <= {sh[6:0], 1'b0};
            bcnt <= bcnt + 3'd1;
          end
          MACK: begin
            if (rise) mnak <= sda_s;
            else if (fall) begin
              if (mnak) st <= IDLE;
              else begin
                sh  <= rd_data;
                ptr <= ptr + 8'd1;
                st  <= TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_regfile_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull,
  input logic idle,
  input logic wr_en,
  input logic to_hit,
  input logic start_det,
  input logic stop_det
);
  assert_pull_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_s));
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> idle);
  assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (idle && !wr_en));
  assert_start_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!idle && !sda_pull));
endmodule

bind i2c_regfile_target i2c_regfile_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull), .idle(idle),
  .wr_en(wr_en), .to_hit(to_hit), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/i2c_regfile_target_bench.sv
`timescale 1ns/1ps
module i2c_regfile_target_bench;
  localparam logic [6:0] DEV = 7'h68;
  localparam int TMO = 200;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, wr_en, wr_is_ram;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [15:0] wq [$];
  int total = 0, bad = 0, wr_seen = 0;
  logic [7:0] exp_ptr = 8'h00;
  bit must_release = 1'b0, done = 1'b0;
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;
  assign rd_data = mem[rd_addr];

  i2c_regfile_target #(.DEV_ADDR(DEV), .TIMEOUT_CYC(TMO)) u_i2c_regfile_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_is_ram(wr_is_ram),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (must_release) chk("R6/R8 sda released", sda_pull, 0);
    if (wr_en) begin
      wr_seen++;
      if (wq.size() == 0) chk("R2 unexpected write", {wr_addr, wr_data}, 16'hxxxx);
      else chk("R2 write addr/data", {wr_addr, wr_data}, wq.pop_front());
      chk("R5 ram decode", wr_is_ram, (wr_addr >= 8'h14));
      mem[wr_addr] = wr_data;
    end
  end

  task automatic tick(int n); repeat (n) @(posedge clk); endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    @(negedge clk); acked = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(logic nak, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      @(negedge clk); d[i] = sda_line;
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    put_bit(nak);
  endtask

  task automatic write_seq(logic [7:0] p, int n, logic [7:0] d0, logic [7:0] step);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a); chk("R1 address ack (write)", a, 1);
    send_byte(p, a); chk("R2 pointer byte ack", a, 1);
    exp_ptr = p;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = d0 + step * 8'(k);
      wq.push_back({exp_ptr, d});
      ref_mem[exp_ptr] = d;
      send_byte(d, a); chk("R2 data ack", a, 1);
      exp_ptr = exp_ptr + 8'd1;
    end
    bus_stop; tick(Q);
  endtask

  task automatic read_seq(int n);
    logic a;
    logic [7:0] d;
    bus_start;
    send_byte({DEV, 1'b1}, a); chk("R1 address ack (read)", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      chk("R4 read data at pointer", d, ref_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    tick(2); chk("R6 released after master NACK", sda_pull, 0);
    bus_stop; tick(Q);
  endtask

  initial begin
    logic a;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    tick(5);
    @(negedge clk);
    chk("R10 reset sda released", sda_pull, 0);
    chk("R10 reset no write", wr_en, 0);
    rst_n = 1'b1; tick(5);

    read_seq(2);

    write_seq(8'h12, 3, 8'hA1, 8'h01);
    chk("R2 write count after boundary burst", wr_seen, 3);
    write_seq(8'h12, 0, 8'h00, 8'h00);
    chk("R2 pointer-only write stores nothing", wr_seen, 3);
    read_seq(3);
    read_seq(1);

    write_seq(8'hFE, 4, 8'h5A, 8'h11);
    chk("R3 pointer wrapped to 02h", exp_ptr, 8'h02);
    write_seq(8'hFE, 0, 8'h00, 8'h00);
    read_seq(4);

    bus_start;
    send_byte({7'h22, 1'b0}, a); chk("R1 foreign address not acked", a, 0);
    must_release = 1'b1;
    send_byte(8'h30, a); chk("R1 ignored until START", a, 0);
    send_byte(8'h99, a); chk("R1 ignored until START", a, 0);
    must_release = 1'b0;
    bus_stop; tick(Q);
    chk("R1 no write from foreign transfer", wr_seen, 7);

    bus_start;
    send_byte({DEV, 1'b0}, a); chk("R1 address ack", a, 1);
    send_byte(8'h40, a); chk("R2 pointer byte ack", a, 1);
    exp_ptr = 8'h40;
    for (int i = 7; i >= 4; i--) put_bit(8'hC5 >> i);
    tick(TMO + 50);
    must_release = 1'b1;
    for (int i = 3; i >= 0; i--) put_bit(8'hC5 >> i);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    @(negedge clk); a = ~sda_line; chk("R8 no ack after timeout", a, 0);
    tick(Q); scl_m = 1'b0; tick(Q);
    must_release = 1'b0;
    bus_stop; tick(Q);
    chk("R8 partial byte discarded", wr_seen, 7);
    read_seq(1);

    bus_start;
    send_byte({DEV, 1'b0}, a); chk("R1 address ack", a, 1);
    send_byte(8'h50, a); chk("R2 pointer byte ack", a, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start;
    send_byte({DEV, 1'b0}, a); chk("R9 address ack after repeated START", a, 1);
    send_byte(8'h60, a); chk("R9 pointer ack after repeated START", a, 1);
    wq.push_back({8'h60, 8'h77}); ref_mem[8'h60] = 8'h77;
    send_byte(8'h77, a); chk("R9 data ack", a, 1);
    bus_stop; tick(Q);
    chk("R9 write after resync", wr_seen, 8);
    exp_ptr = 8'h61;
    read_seq(1);
    write_seq(8'h60, 0, 8'h00, 8'h00);
    read_seq(2);

    chk("R2 all expected writes seen", wq.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(190000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule